// File: doc/BRIEF.md
# Memory Security Attribution Checker

This block sorts every processor bus address into one of three security classes: secure, non-secure, or secure-callable. It reads two sources side by side in the same cycle. The first is a table of address windows that software can program. The second is a fixed attribute that arrives on an input with each access. The result always takes the stricter of the two classes, so a secure verdict from either source cannot be weakened by the other. Only a requester in the secure state may change the table. Table writes from a non-secure requester have no effect.

When a non-secure requester touches an address that resolves as secure, the block raises a fault pulse, and the surrounding logic must not grant that access. The resolved class and the fault are registered one cycle after the address is presented. A system with no fixed map ties that input to `2'b00`. If the table is also switched off, every address comes out secure.

Top module: `sec_attr_chk`

## Requirements
- R1: `attr_q` encodes the class as `2'b00` non-secure, `2'b01` secure-callable and `2'b10` secure, and never shows `2'b11`. During and just after reset, `attr_q` is `2'b10` and `fault_q` is 0.
- R2: While the table's global enable is 0 and `fix_attr` is `2'b00`, every address resolves as secure (`2'b10`).
- R3: An address lies inside an enabled region when its bits above bit 4 lie between the region's base and limit bits above bit 4, both ends included. A region's limit therefore covers its whole 32-byte block. An address inside exactly one enabled region gives non-secure when that region's callable bit is 0, and secure-callable when it is 1.
- R4: An address inside no enabled region resolves as secure, even with the table enabled.
- R5: An address inside two or more enabled regions resolves as secure.
- R6: A `fix_attr` value with bit 1 set (`2'b10` or `2'b11`) makes the address secure, whatever the table says.
- R7: The two sources merge with secure above secure-callable above non-secure. `fix_attr` `2'b01` with a non-secure table result gives secure-callable. A secure-callable table result with `fix_attr` `2'b00` also gives secure-callable.
- R8: `fault_q` is 1 exactly when the access just captured had `acc_valid`=1 and `acc_ns`=1 and resolved as secure. Secure requesters never fault. Non-secure requesters reaching non-secure or secure-callable addresses do not fault.
- R9: When `wr_en`=1 and `wr_secure`=1, `wr_sel` picks the target:
  - `2'b00` loads region `wr_idx` base from `wr_data` bits above bit 4.
  - `2'b01` loads that region's limit the same way.
  - `2'b10` loads that region's enable (`wr_data[0]`) and callable bit (`wr_data[1]`).
  - `2'b11` loads the global table enable (`wr_data[0]`).
  
  A write with `wr_secure`=0 changes nothing.
- R10: The verdict for an access presented before a clock edge appears on `attr_q`/`fault_q` after that edge. The fault lasts one cycle per offending access. A table write takes effect for accesses presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_ns | input | 1 | Requester is non-secure |
| fix_attr | input | 2 | Fixed-map attribute for this access (00 NS, 01 NSC, 1x S) |
| wr_en | input | 1 | Table write strobe |
| wr_secure | input | 1 | Writer is in the secure state |
| wr_sel | input | 2 | Table field select |
| wr_idx | input | IDX_W | Region index for the write |
| wr_data | input | ADDR_W | Write data |
| attr_q | output | 2 | Resolved attribute, registered |
| fault_q | output | 1 | One-cycle fault for a non-secure access to secure memory |

## Verification
The assertions assume two things about the inputs. First, `fix_attr`, `acc_valid` and `acc_ns` carry defined values from reset onward, because several properties look one cycle back at them. Second, no write and no access are in flight while reset is asserted. The stimulus meets both conditions:
- It drives every input to a known value before the first clock edge.
- It holds the access and write strobes low until reset has been released.
- It changes inputs only at falling edges, so each access and each write occupies exactly one rising edge.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

   typedef enum logic [1:0] {
      ATTR_NS  = 2'b00,
      ATTR_NSC = 2'b01,
      ATTR_S   = 2'b10
   } attr_t;

   typedef enum logic [1:0] {
      SEL_BASE  = 2'b00,
      SEL_LIMIT = 2'b01,
      SEL_RCTL  = 2'b10,
      SEL_GCTL  = 2'b11
   } wsel_t;

   // stricter of two classes: secure > secure-callable > non-secure
   function automatic attr_t attr_strict(attr_t a, attr_t b);
      if (a == ATTR_S || b == ATTR_S)
         return ATTR_S;
      if (a == ATTR_NSC || b == ATTR_NSC)
         return ATTR_NSC;
      return ATTR_NS;
   endfunction

   // fixed-map input: bit 1 forces secure, else bit 0 selects callable
   function automatic attr_t fix_decode(logic [1:0] f);
      if (f[1])
         return ATTR_S;
      if (f[0])
         return ATTR_NSC;
      return ATTR_NS;
   endfunction

endpackage

// File: rtl/sec_attr_regs.sv
module sec_attr_regs
   import sec_attr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_REG     = 8,
   parameter int GRAN_LOG2 = 5,
   localparam int IDX_W    = (N_REG > 1) ? $clog2(N_REG) : 1,
   localparam int PAGE_W   = ADDR_W - GRAN_LOG2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          wr_secure,
   input  logic [1:0]                    wr_sel,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [ADDR_W-1:0]             wr_data,
   output logic                          tbl_en,
   output logic [N_REG-1:0]              reg_en,
   output logic [N_REG-1:0]              reg_nsc,
   output logic [N_REG-1:0][PAGE_W-1:0]  reg_base,
   output logic [N_REG-1:0][PAGE_W-1:0]  reg_limit
);

   logic  wr_ok;
   wsel_t sel;

   assign wr_ok = wr_en && wr_secure;
   assign sel   = wsel_t'(wr_sel);

   always_ff @(posedge clk) begin
      if (!rst_n)
         tbl_en <= 1'b0;
      else if (wr_ok && sel == SEL_GCTL)
         tbl_en <= wr_data[0];
   end

   for (genvar g = 0; g < N_REG; g++) begin : g_region
      logic hit_idx;
      assign hit_idx = wr_ok && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            reg_en[g]    <= 1'b0;
            reg_nsc[g]   <= 1'b0;
            reg_base[g]  <= '0;
            reg_limit[g] <= '0;
         end else if (hit_idx) begin
            unique case (sel)
               SEL_BASE:  reg_base[g]  <= wr_data[ADDR_W-1:GRAN_LOG2];
               SEL_LIMIT: reg_limit[g] <= wr_data[ADDR_W-1:GRAN_LOG2];
               SEL_RCTL: begin
                  reg_en[g]  <= wr_data[0];
                  reg_nsc[g] <= wr_data[1];
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/sec_attr_lookup.sv
module sec_attr_lookup
   import sec_attr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int N_REG     = 8,
   parameter int GRAN_LOG2 = 5,
   localparam int PAGE_W   = ADDR_W - GRAN_LOG2
) (
   input  logic                          tbl_en,
   input  logic [N_REG-1:0]              reg_en,
   input  logic [N_REG-1:0]              reg_nsc,
   input  logic [N_REG-1:0][PAGE_W-1:0]  reg_base,
   input  logic [N_REG-1:0][PAGE_W-1:0]  reg_limit,
   input  logic [ADDR_W-1:0]             addr,
   output attr_t                         tbl_attr
);

   logic [PAGE_W-1:0] page;
   logic [N_REG-1:0]  hit;
   logic              any_hit;
   logic              multi_hit;
   logic              hit_nsc;

   assign page = addr[ADDR_W-1:GRAN_LOG2];

   // every region compared at once
   for (genvar g = 0; g < N_REG; g++) begin : g_cmp
      assign hit[g] = reg_en[g] &&
                      (page >= reg_base[g]) &&
                      (page <= reg_limit[g]);
   end

   always_comb begin
      any_hit   = 1'b0;
      multi_hit = 1'b0;
      hit_nsc   = 1'b0;
      for (int i = 0; i < N_REG; i++) begin
         if (hit[i]) begin
            multi_hit = multi_hit | any_hit;
            any_hit   = 1'b1;
            hit_nsc   = hit_nsc | reg_nsc[i];
         end
      end
   end

   always_comb begin
      if (!tbl_en || !any_hit || multi_hit)
         tbl_attr = ATTR_S;
      else if (hit_nsc)
         tbl_attr = ATTR_NSC;
      else
         tbl_attr = ATTR_NS;
   end

endmodule

// File: rtl/sec_attr_merge.sv
module sec_attr_merge
   import sec_attr_pkg::*;
#(
   parameter bit FIX_PRESENT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        acc_valid,
   input  logic        acc_ns,
   input  attr_t       tbl_attr,
   input  logic [1:0]  fix_attr,
   output logic [1:0]  attr_q,
   output logic        fault_q
);

   attr_t fix_cls;
   attr_t merged;

   if (FIX_PRESENT) begin : g_fix
      assign fix_cls = fix_decode(fix_attr);
   end else begin : g_nofix
      logic unused_fix;
      assign unused_fix = ^fix_attr;
      assign fix_cls    = ATTR_NS;
   end

   assign merged = attr_strict(tbl_attr, fix_cls);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         attr_q  <= ATTR_S;
         fault_q <= 1'b0;
      end else begin
         attr_q  <= merged;
         fault_q <= acc_valid && acc_ns && (merged == ATTR_S);
      end
   end

endmodule

// File: rtl/sec_attr_chk.sv
module sec_attr_chk
   import sec_attr_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int N_REG       = 8,
   parameter int GRAN_LOG2   = 5,
   parameter bit FIX_PRESENT = 1'b1,
   localparam int IDX_W      = (N_REG > 1) ? $clog2(N_REG) : 1,
   localparam int PAGE_W     = ADDR_W - GRAN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_ns,
   input  logic [1:0]        fix_attr,
   input  logic              wr_en,
   input  logic              wr_secure,
   input  logic [1:0]        wr_sel,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [1:0]        attr_q,
   output logic              fault_q
);

   if (N_REG < 1 || N_REG > 64) begin : g_bad_nreg
      $error("sec_attr_chk: N_REG out of range");
   end
   if (GRAN_LOG2 < 1 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
      $error("sec_attr_chk: GRAN_LOG2 must be below ADDR_W");
   end

   logic                          tbl_en;
   logic [N_REG-1:0]              reg_en;
   logic [N_REG-1:0]              reg_nsc;
   logic [N_REG-1:0][PAGE_W-1:0]  reg_base;
   logic [N_REG-1:0][PAGE_W-1:0]  reg_limit;
   attr_t                         tbl_attr;

   sec_attr_regs #(
      .ADDR_W(ADDR_W), .N_REG(N_REG), .GRAN_LOG2(GRAN_LOG2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_secure(wr_secure), .wr_sel(wr_sel),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .tbl_en(tbl_en), .reg_en(reg_en), .reg_nsc(reg_nsc),
      .reg_base(reg_base), .reg_limit(reg_limit)
   );

   sec_attr_lookup #(
      .ADDR_W(ADDR_W), .N_REG(N_REG), .GRAN_LOG2(GRAN_LOG2)
   ) u_lookup (
      .tbl_en(tbl_en), .reg_en(reg_en), .reg_nsc(reg_nsc),
      .reg_base(reg_base), .reg_limit(reg_limit),
      .addr(acc_addr), .tbl_attr(tbl_attr)
   );

   sec_attr_merge #(
      .FIX_PRESENT(FIX_PRESENT)
   ) u_merge (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_ns(acc_ns),
      .tbl_attr(tbl_attr), .fix_attr(fix_attr),
      .attr_q(attr_q), .fault_q(fault_q)
   );

endmodule

// File: rtl/sec_attr_chk_sva.sv
module sec_attr_chk_sva #(
   parameter int N_REG       = 8,
   parameter bit FIX_PRESENT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_ns,
   input logic [1:0]       fix_attr,
   input logic             wr_en,
   input logic             wr_secure,
   input logic             tbl_en,
   input logic [N_REG-1:0] reg_en,
   input logic [N_REG-1:0] reg_nsc,
   input logic [1:0]       attr_q,
   input logic             fault_q
);

   assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      attr_q != 2'b11);

   assert_disabled_secure_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_en |=> attr_q == 2'b10);

   if (FIX_PRESENT) begin : g_fix_chk
      assert_fixed_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         fix_attr[1] |=> attr_q == 2'b10);
   end

   assert_fault_needs_secure_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> attr_q == 2'b10);

   assert_fault_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_ns) |=> (fault_q == (attr_q == 2'b10)));

   assert_no_stray_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_ns) |=> !fault_q);

   assert_ns_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_secure) |=> ($stable(tbl_en) && $stable(reg_en) && $stable(reg_nsc)));

endmodule

bind sec_attr_chk sec_attr_chk_sva #(
   .N_REG(N_REG), .FIX_PRESENT(FIX_PRESENT)
) u_sva (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_ns(acc_ns), .fix_attr(fix_attr),
   .wr_en(wr_en), .wr_secure(wr_secure),
   .tbl_en(tbl_en), .reg_en(reg_en), .reg_nsc(reg_nsc),
   .attr_q(attr_q), .fault_q(fault_q)
);

// File: tb/sim_sec_attr_chk.sv
`timescale 1ns/1ps
module sim_sec_attr_chk;

   localparam logic [1:0] A_NS  = 2'b00;
   localparam logic [1:0] A_NSC = 2'b01;
   localparam logic [1:0] A_S   = 2'b10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_ns = 1'b0;
   logic [1:0]  fix_attr = 2'b00;
   logic        wr_en = 1'b0;
   logic        wr_secure = 1'b0;
   logic [1:0]  wr_sel = 2'b00;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  attr_q;
   logic        fault_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sec_attr_chk u0 (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_ns(acc_ns),
      .fix_attr(fix_attr),
      .wr_en(wr_en), .wr_secure(wr_secure), .wr_sel(wr_sel),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .attr_q(attr_q), .fault_q(fault_q)
   );

   task automatic check(string req, logic [1:0] act_a, logic [1:0] exp_a,
                        logic act_f, logic exp_f);
      checks++;
      if (act_a !== exp_a || act_f !== exp_f) begin
         errors++;
         $display("FAIL %s: attr=%b fault=%b expected attr=%b fault=%b",
                  req, act_a, act_f, exp_a, exp_f);
      end
   endtask

   task automatic wr(logic sec, logic [1:0] sel, logic [2:0] idx, logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_secure = sec; wr_sel = sel; wr_idx = idx; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0; wr_secure = 1'b0;
   endtask

   task automatic access(string req, logic [31:0] addr, logic ns, logic [1:0] fix,
                         logic [1:0] exp_a, logic exp_f);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = addr; acc_ns = ns; fix_attr = fix;
      @(negedge clk);
      acc_valid = 1'b0;
      check(req, attr_q, exp_a, fault_q, exp_f);
      fix_attr = 2'b00;
   endtask

   task automatic t_reset();
      check("R1 reset", attr_q, A_S, fault_q, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", attr_q, A_S, fault_q, 1'b0);
   endtask

   task automatic t_disabled();
      access("R2 disabled low addr", 32'h0000_0000, 1'b1, 2'b00, A_S, 1'b1);
      access("R2 disabled high addr", 32'hFFFF_FFE4, 1'b1, 2'b00, A_S, 1'b1);
   endtask

   task automatic t_program();
      wr(1'b1, 2'b00, 3'd0, 32'h0000_1000);
      wr(1'b1, 2'b01, 3'd0, 32'h0000_1FE0);
      wr(1'b1, 2'b10, 3'd0, 32'h0000_0001);
      wr(1'b1, 2'b00, 3'd1, 32'h0000_4000);
      wr(1'b1, 2'b01, 3'd1, 32'h0000_40E0);
      wr(1'b1, 2'b10, 3'd1, 32'h0000_0003);
      wr(1'b1, 2'b11, 3'd0, 32'h0000_0001);
   endtask

   task automatic t_match();
      access("R3 base NS", 32'h0000_1000, 1'b1, 2'b00, A_NS, 1'b0);
      access("R3 inclusive limit block", 32'h0000_1FFF, 1'b1, 2'b00, A_NS, 1'b0);
      access("R3 callable region", 32'h0000_4010, 1'b1, 2'b00, A_NSC, 1'b0);
      access("R4 above limit", 32'h0000_2000, 1'b1, 2'b00, A_S, 1'b1);
      access("R4 below base", 32'h0000_0FFF, 1'b1, 2'b00, A_S, 1'b1);
   endtask

   task automatic t_overlap();
      wr(1'b1, 2'b00, 3'd2, 32'h0000_1800);
      wr(1'b1, 2'b01, 3'd2, 32'h0000_1800);
      wr(1'b1, 2'b10, 3'd2, 32'h0000_0001);
      access("R5 overlap", 32'h0000_181F, 1'b1, 2'b00, A_S, 1'b1);
      access("R5 outside overlap", 32'h0000_1820, 1'b1, 2'b00, A_NS, 1'b0);
   endtask

   task automatic t_fixed();
      access("R6 fixed 10", 32'h0000_1000, 1'b1, 2'b10, A_S, 1'b1);
      access("R6 fixed 11", 32'h0000_4000, 1'b1, 2'b11, A_S, 1'b1);
      access("R7 fixed NSC over table NS", 32'h0000_1000, 1'b1, 2'b01, A_NSC, 1'b0);
      access("R7 table NSC over fixed NS", 32'h0000_40FF, 1'b1, 2'b00, A_NSC, 1'b0);
   endtask

   task automatic t_requester();
      access("R8 secure requester", 32'h0000_2000, 1'b0, 2'b00, A_S, 1'b0);
      access("R8 secure requester NS", 32'h0000_1000, 1'b0, 2'b00, A_NS, 1'b0);
   endtask

   task automatic t_pulse();
      access("R10 fault pulse", 32'h0000_3000, 1'b1, 2'b00, A_S, 1'b1);
      @(negedge clk);
      check("R10 fault one cycle", attr_q, A_S, fault_q, 1'b0);
   endtask

   task automatic t_write_guard();
      wr(1'b0, 2'b10, 3'd0, 32'h0000_0000);
      wr(1'b0, 2'b11, 3'd0, 32'h0000_0000);
      wr(1'b0, 2'b10, 3'd3, 32'h0000_0003);
      access("R9 NS write ignored region", 32'h0000_1000, 1'b1, 2'b00, A_NS, 1'b0);
      access("R9 NS write ignored new region", 32'h0000_0000, 1'b1, 2'b00, A_S, 1'b1);
      wr(1'b1, 2'b10, 3'd0, 32'h0000_0000);
      access("R10 secure write takes effect", 32'h0000_1000, 1'b1, 2'b00, A_S, 1'b1);
      wr(1'b1, 2'b11, 3'd0, 32'h0000_0000);
      access("R2 table off again", 32'h0000_4010, 1'b1, 2'b00, A_S, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_disabled();
      t_program();
      t_match();
      t_overlap();
      t_fixed();
      t_requester();
      t_pulse();
      t_write_guard();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule